// File: doc/BRIEF.md
# Pseudo-Static RAM Bus Responder with Refresh Stall

This block plays the memory side of an eight-bit, double-data-rate pseudo-static RAM bus. It lets a host controller's testbench talk to a realistic partner. The block runs on one fast system clock and samples the bus clock, chip select and data lines. Every change of level on the bus clock, rising or falling, counts as one bus edge. After chip select falls, the first six bus edges carry a 48-bit command header, most significant byte first. A latency phase follows, and then the data bytes, one per bus edge, high byte of each 16-bit word first.

An internal refresh timer models the hidden refresh of a DRAM core. If a refresh is due when an access starts, the responder drives the strobe line high during the header. That requests twice the initial latency, and the pending refresh is retired once the longer stall has elapsed. A configuration bit can force the long latency on every access, which makes the timing deterministic. A read-only register reports the geometry of the word array in row and column bits.

The host sees read data with a strobe that toggles alongside each byte. On writes it masks individual bytes by driving the strobe line high. Raising chip select abandons whatever is in progress.

Top module: `psram_responder`

## Requirements
- R1: After chip select falls, the six bytes on the next six bus edges form the header, first byte in bits 47..40. Bit 47 set means read, bit 46 set means register space, and bit 45 set means linear burst (clear means wrapped).
- R2: The start word address is header bits 34..16 followed by header bits 2..0, a 22-bit value of which the low ADDR_W bits are used. Header bits 44..35 and 15..3 have no effect.
- R3: While the header is received, rwds_oe is 1 and rwds_out is 1 exactly when the access gets long latency. The latency phase then lasts 2*LAT_CLK bus edges (short) or 4*LAT_CLK bus edges (long), with rwds_oe=1 and rwds_out=0.
- R4: Register 1, bit 0, is the fixed-latency bit (reset 0). While it is set, every access gets long latency. A write to register 1 with its low byte masked leaves the bit unchanged.
- R5: A refresh becomes pending on every REFRESH_PERIOD-th rising bus-clock edge. An access that starts while a refresh is pending gets long latency, and the pending refresh clears on the last edge of that long latency phase.
- R6: Write data arrives one word per two bus edges, high byte first. A byte sent with rwds_in=1 is not written.
- R7: During read data, dq_oe=1 and each bus edge presents the next byte, high byte first. rwds_out is 1 with a high byte and 0 with a low byte.
- R8: Register 0 reads as {ROW_W, COL_W}, 8 bits each (0x0503 by default), and writes to it have no effect. Other register addresses above 1 read 0.
- R9: The address steps after each word. In wrapped mode it stays inside the aligned group of WRAP_WORDS words. In linear mode it runs on and wraps only at the end of the array.
- R10: One clock after chip select rises, dq_oe and rwds_oe are 0. A word with only its high byte received is not written, and the next chip-select fall starts a fresh header.
- R11: After reset the outputs are released, no refresh is pending and the fixed-latency bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| ck | input | 1 | Bus clock; both edges carry bytes |
| dq_in | input | 8 | Byte driven by the host |
| rwds_in | input | 1 | Host strobe line: byte mask during write data |
| dq_out | output | 8 | Byte driven by the responder |
| dq_oe | output | 1 | Responder drives the data bus |
| rwds_out | output | 1 | Latency request in header, strobe during read data |
| rwds_oe | output | 1 | Responder drives the strobe line |

## Verification
A header counter or shift register that slips by one edge shows up on the very next access: either the latency request is sampled at the wrong time or the first read word comes from a neighbouring address. A refresh flag that fails to set or clear changes the latency of a later access and shifts every data byte by 2*LAT_CLK edges. That shift appears within one transaction, because the bench counts latency from its own refresh model rather than from the responder's request. Mask or address-stepping faults stay hidden until the affected word is read back, so each write pattern in the bench is followed by a read of the same range.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_LAT,
    ST_DATA
  } psr_state_e;

  typedef struct packed {
    logic        rd;
    logic        regsp;
    logic        lin;
    logic [21:0] addr;
  } psr_cmd_t;

  // Split the 48-bit header into command fields; reserved bits are dropped.
  function automatic psr_cmd_t decode_hdr(input logic [47:0] h);
    psr_cmd_t c;
    c.rd    = h[47];
    c.regsp = h[46];
    c.lin   = h[45];
    c.addr  = {h[34:16], h[2:0]};
    return c;
  endfunction

  // Next word address: either inside an aligned wrap group or across the array.
  function automatic logic [21:0] step_addr(input logic [21:0] a,
                                            input logic        lin,
                                            input logic [21:0] wrap_mask,
                                            input logic [21:0] depth_mask);
    logic [21:0] inc;
    inc = a + 22'd1;
    if (lin) return inc & depth_mask;
    return (a & ~wrap_mask) | (inc & wrap_mask);
  endfunction

  // Register-space read value.
  function automatic logic [15:0] reg_word(input logic [21:0] a,
                                           input logic        fixed,
                                           input logic [7:0]  rows,
                                           input logic [7:0]  cols);
    if (a == 22'd0) return {rows, cols};
    if (a == 22'd1) return {15'd0, fixed};
    return 16'd0;
  endfunction

endpackage

// File: rtl/psr_bus_sync.sv
module psr_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ck,
  input  logic cs_n,
  output logic ck_edge,
  output logic ck_rise,
  output logic cs_fall
);

  logic ck_q;
  logic cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_q <= 1'b0;
      cs_q <= 1'b1;
    end else begin
      ck_q <= ck;
      cs_q <= cs_n;
    end
  end

  assign ck_edge = ck ^ ck_q;
  assign ck_rise = ck & ~ck_q;
  assign cs_fall = cs_q & ~cs_n;

endmodule

// File: rtl/psr_refresh.sv
module psr_refresh #(
  parameter int PERIOD = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic stall_done,
  output logic pend
);

  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;
  logic          hit;

  assign hit = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (tick) cnt <= hit ? '0 : cnt + CW'(1);
      if (hit) pend <= 1'b1;
      else if (stall_done) pend <= 1'b0;
    end
  end

  a_r5_pend_set : assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend);
  a_r5_pend_clear : assert property (@(posedge clk) disable iff (!rst_n)
    (stall_done && !hit) |=> !pend);
  a_r11_count_range : assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: rtl/psr_array.sv
module psr_array #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [15:0]       wdata,
  input  logic [1:0]        be,
  input  logic [ADDR_W-1:0] raddr,
  output logic [15:0]       rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [15:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      if (be[1]) mem[waddr][15:8] <= wdata[15:8];
      if (be[0]) mem[waddr][7:0]  <= wdata[7:0];
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
#(
  parameter int LAT_CLK    = 3,
  parameter int ADDR_W     = 8,
  parameter int WRAP_WORDS = 16,
  parameter int ROW_W      = 5,
  parameter int COL_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ck_edge,
  input  logic              cs_fall,
  input  logic [7:0]        dq_in,
  input  logic              rwds_in,
  input  logic              refresh_pend,
  input  logic [15:0]       mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  output logic [1:0]        mem_be,
  output logic              stall_done,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic              rwds_out,
  output logic              rwds_oe
);

  localparam int LAT_SHORT = 2 * LAT_CLK;
  localparam int LAT_LONG  = 4 * LAT_CLK;
  localparam int LCW       = $clog2(LAT_LONG + 1);
  localparam int CW        = (LCW > 3) ? LCW : 3;
  localparam logic [21:0] DEPTH_MASK = 22'((64'd1 << ADDR_W) - 64'd1);
  localparam logic [21:0] WRAP_MASK  = 22'(WRAP_WORDS - 1);
  localparam logic [7:0]  ROWS_V     = 8'(ROW_W);
  localparam logic [7:0]  COLS_V     = 8'(COL_W);

  psr_state_e    state;
  logic [CW-1:0] cnt;
  logic [39:0]   hdr_q;
  logic          long_lat;
  logic          is_rd, is_reg, is_lin;
  logic [21:0]   addr;
  logic          ph;
  logic [7:0]    hi_byte;
  logic          hi_mask;
  logic          strobe;
  logic          fixed_lat;

  // Named events for the assertions and for readability.
  logic          bus_act;
  logic          hdr_last;
  logic          lat_last;
  logic          rd_edge;
  logic          wr_commit;
  psr_cmd_t      cmd_dec;
  logic [CW-1:0] lat_edges;
  logic [15:0]   rd_word;
  logic [21:0]   addr_nxt;

  assign bus_act   = !cs_n && !cs_fall && ck_edge;
  assign lat_edges = long_lat ? CW'(LAT_LONG) : CW'(LAT_SHORT);
  assign hdr_last  = (state == ST_HDR) && (cnt == CW'(5));
  assign lat_last  = (state == ST_LAT) && (cnt == lat_edges - CW'(1));
  assign cmd_dec   = decode_hdr({hdr_q, dq_in});
  assign rd_edge   = bus_act && (state == ST_DATA) && is_rd;
  assign wr_commit = bus_act && (state == ST_DATA) && !is_rd && ph;
  assign rd_word   = is_reg ? reg_word(addr, fixed_lat, ROWS_V, COLS_V) : mem_rdata;
  assign addr_nxt  = step_addr(addr, is_lin, WRAP_MASK, DEPTH_MASK);

  assign stall_done = bus_act && lat_last && long_lat;

  assign mem_addr  = addr[ADDR_W-1:0];
  assign mem_we    = wr_commit && !is_reg;
  assign mem_wdata = {hi_byte, dq_in};
  assign mem_be    = {~hi_mask, ~rwds_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      hdr_q     <= '0;
      long_lat  <= 1'b0;
      is_rd     <= 1'b0;
      is_reg    <= 1'b0;
      is_lin    <= 1'b0;
      addr      <= '0;
      ph        <= 1'b0;
      hi_byte   <= '0;
      hi_mask   <= 1'b0;
      strobe    <= 1'b0;
      dq_out    <= '0;
      fixed_lat <= 1'b0;
    end else if (cs_n) begin
      state <= ST_IDLE;
    end else if (cs_fall) begin
      state    <= ST_HDR;
      cnt      <= '0;
      long_lat <= refresh_pend | fixed_lat;
    end else if (ck_edge) begin
      unique case (state)
        ST_HDR: begin
          hdr_q <= {hdr_q[31:0], dq_in};
          if (hdr_last) begin
            is_rd  <= cmd_dec.rd;
            is_reg <= cmd_dec.regsp;
            is_lin <= cmd_dec.lin;
            addr   <= cmd_dec.addr & DEPTH_MASK;
            state  <= ST_LAT;
            cnt    <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_LAT: begin
          if (lat_last) begin
            state  <= ST_DATA;
            ph     <= 1'b0;
            strobe <= 1'b0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_DATA: begin
          if (is_rd) begin
            dq_out <= ph ? rd_word[7:0] : rd_word[15:8];
            strobe <= !ph;
            if (ph) addr <= addr_nxt;
          end else if (!ph) begin
            hi_byte <= dq_in;
            hi_mask <= rwds_in;
          end else begin
            if (is_reg && addr == 22'd1 && !rwds_in) fixed_lat <= dq_in[0];
            addr <= addr_nxt;
          end
          ph <= !ph;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dq_oe    = (state == ST_DATA) && is_rd;
  assign rwds_oe  = (state == ST_HDR) || (state == ST_LAT) || dq_oe;
  assign rwds_out = (state == ST_HDR) ? long_lat : (dq_oe ? strobe : 1'b0);

  a_r1_hdr_len : assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LAT && $past(state) == ST_HDR) |-> $past(cnt) == CW'(5));
  a_r4_fixed_forces_long : assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HDR && fixed_lat) |-> rwds_out);
  a_r5_pending_forces_long : assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && refresh_pend) |=> (cs_n || rwds_out));
  a_r3_latency_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LAT) |-> (rwds_oe && !rwds_out && !dq_oe));
  a_r7_strobe_toggles : assert property (@(posedge clk) disable iff (!rst_n)
    rd_edge |=> (!dq_oe || rwds_out != $past(rwds_out)));
  a_r9_wrap_group : assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && $past(state) == ST_DATA && !is_lin)
      |-> (addr & ~WRAP_MASK) == ($past(addr) & ~WRAP_MASK));
  a_r10_release : assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!dq_oe && !rwds_oe));
  a_r6_write_only_in_write : assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (!cs_n && !is_rd && state == ST_DATA));

endmodule

// File: rtl/psram_responder.sv
module psram_responder #(
  parameter int ROW_W          = 5,
  parameter int COL_W          = 3,
  parameter int LAT_CLK        = 3,
  parameter int WRAP_WORDS     = 16,
  parameter int REFRESH_PERIOD = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       ck,
  input  logic [7:0] dq_in,
  input  logic       rwds_in,
  output logic [7:0] dq_out,
  output logic       dq_oe,
  output logic       rwds_out,
  output logic       rwds_oe
);

  localparam int ADDR_W = ROW_W + COL_W;

  logic              ck_edge, ck_rise, cs_fall;
  logic              refresh_pend, stall_done;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [15:0]       mem_wdata, mem_rdata;
  logic [1:0]        mem_be;

  psr_bus_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .ck      (ck),
    .cs_n    (cs_n),
    .ck_edge (ck_edge),
    .ck_rise (ck_rise),
    .cs_fall (cs_fall)
  );

  psr_refresh #(.PERIOD(REFRESH_PERIOD)) u_refresh (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (ck_rise),
    .stall_done (stall_done),
    .pend       (refresh_pend)
  );

  psr_array #(.ADDR_W(ADDR_W)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (mem_wdata),
    .be    (mem_be),
    .raddr (mem_addr),
    .rdata (mem_rdata)
  );

  psr_ctrl #(
    .LAT_CLK    (LAT_CLK),
    .ADDR_W     (ADDR_W),
    .WRAP_WORDS (WRAP_WORDS),
    .ROW_W      (ROW_W),
    .COL_W      (COL_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .ck_edge      (ck_edge),
    .cs_fall      (cs_fall),
    .dq_in        (dq_in),
    .rwds_in      (rwds_in),
    .refresh_pend (refresh_pend),
    .mem_rdata    (mem_rdata),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_be       (mem_be),
    .stall_done   (stall_done),
    .dq_out       (dq_out),
    .dq_oe        (dq_oe),
    .rwds_out     (rwds_out),
    .rwds_oe      (rwds_oe)
  );

endmodule

// File: tb/psram_responder_tb.sv
module psram_responder_tb;

  localparam int LAT = 3;
  localparam int RP  = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       ck = 1'b0;
  logic [7:0] dq_in = '0;
  logic       rwds_in = 1'b0;
  logic [7:0] dq_out;
  logic       dq_oe, rwds_out, rwds_oe;

  always #2 clk = ~clk;

  psram_responder u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ck(ck), .dq_in(dq_in),
    .rwds_in(rwds_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .rwds_out(rwds_out), .rwds_oe(rwds_oe)
  );

  // op: 0 write array, 1 read array, 2 write register, 3 read register
  // mask: [3:2] = {hi,lo} of word 0, [1:0] = {hi,lo} of word 1
  typedef struct packed {
    logic [1:0]  op;
    logic        lin;
    logic [21:0] addr;
    logic [3:0]  n;
    logic [15:0] seed;
    logic [3:0]  mask;
    logic [15:0] exp0;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 22'h155510, 4'd4, 16'hA100, 4'h0, 16'h0000},
    '{2'd1, 1'b1, 22'h000010, 4'd4, 16'h0000, 4'h0, 16'hA100},
    '{2'd0, 1'b0, 22'h00002E, 4'd4, 16'hB200, 4'h0, 16'h0000},
    '{2'd1, 1'b1, 22'h000020, 4'd2, 16'h0000, 4'h0, 16'hB402},
    '{2'd0, 1'b0, 22'h00002E, 4'd2, 16'hD411, 4'h6, 16'h0000},
    '{2'd1, 1'b0, 22'h00002E, 4'd4, 16'h0000, 4'h0, 16'hD400},
    '{2'd0, 1'b1, 22'h3FFFFE, 4'd4, 16'hC300, 4'h0, 16'h0000},
    '{2'd1, 1'b1, 22'h0000FF, 4'd3, 16'h0000, 4'h0, 16'hC401},
    '{2'd3, 1'b1, 22'h000000, 4'd1, 16'h0000, 4'h0, 16'h0503},
    '{2'd2, 1'b1, 22'h000000, 4'd1, 16'hFFFF, 4'h0, 16'h0000},
    '{2'd3, 1'b1, 22'h000000, 4'd2, 16'h0000, 4'h0, 16'h0503},
    '{2'd2, 1'b1, 22'h000001, 4'd1, 16'h0001, 4'h0, 16'h0000},
    '{2'd1, 1'b1, 22'h000012, 4'd2, 16'h0000, 4'h0, 16'hA302},
    '{2'd2, 1'b1, 22'h000001, 4'd1, 16'h0000, 4'h4, 16'h0000},
    '{2'd3, 1'b1, 22'h000001, 4'd1, 16'h0000, 4'h0, 16'h0001},
    '{2'd2, 1'b1, 22'h000001, 4'd1, 16'h0000, 4'h0, 16'h0000},
    '{2'd3, 1'b1, 22'h000001, 4'd1, 16'h0000, 4'h0, 16'h0000}
  };

  logic [15:0] shadow [256];
  logic        fixed_m = 1'b0;
  logic        pend_m = 1'b0;
  int          rc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] next_a(input logic [7:0] a, input logic lin);
    if (lin) return a + 8'd1;
    return {a[7:4], a[3:0] + 4'd1};
  endfunction

  function automatic logic [15:0] reg_exp(input logic [7:0] a);
    case (a)
      8'd0: return 16'h0503;
      8'd1: return {15'd0, fixed_m};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic bus_edge(input logic [7:0] d, input logic m);
    @(negedge clk);
    dq_in = d;
    rwds_in = m;
    ck = ~ck;
    if (ck) begin
      rc++;
      if (rc == RP) begin
        rc = 0;
        pend_m = 1'b1;
      end
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic open_txn(input logic rd, input logic sp, input logic lin,
                          input logic [21:0] a);
    logic [47:0] hdr;
    logic        exp_long;
    int          lat;
    hdr = '0;
    hdr[47] = rd;
    hdr[46] = sp;
    hdr[45] = lin;
    hdr[44:35] = 10'h2B5;     // reserved filler, R2
    hdr[34:16] = a[21:3];
    hdr[15:3] = 13'h1A5A;     // reserved filler, R2
    hdr[2:0] = a[2:0];
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    exp_long = pend_m | fixed_m;
    chk(pend_m ? "R5 header latency request" :
        (fixed_m ? "R4 header latency request" : "R3 header latency request"),
        {30'd0, rwds_oe, rwds_out}, {30'd0, 1'b1, exp_long});
    for (int i = 0; i < 6; i++) bus_edge(hdr[47 - 8 * i -: 8], 1'b0);
    lat = exp_long ? 4 * LAT : 2 * LAT;
    for (int i = 0; i < lat; i++) begin
      bus_edge(8'h00, 1'b0);
      if (i == 0) chk("R3 latency strobe low", {30'd0, rwds_oe, rwds_out}, 32'd2);
      if (i == lat - 1 && exp_long) pend_m = 1'b0;
    end
  endtask

  task automatic close_txn;
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 release after chip select", {30'd0, dq_oe, rwds_oe}, 32'd0);
    if (ck) bus_edge(8'h00, 1'b0);
  endtask

  task automatic run_vec(input vec_t v);
    logic [7:0]  a;
    logic [15:0] w, e;
    logic        mh, ml;
    a = v.addr[7:0];
    open_txn(v.op[0], v.op[1], v.lin, v.addr);
    for (int k = 0; k < int'(v.n); k++) begin
      if (v.op[0]) begin
        e = v.op[1] ? reg_exp(a) : shadow[a];
        bus_edge(8'h00, 1'b0);
        chk(v.op[1] ? "R8 register read high" : "R7 read high byte",
            {22'd0, dq_oe, rwds_out, dq_out}, {22'd0, 1'b1, 1'b1, e[15:8]});
        bus_edge(8'h00, 1'b0);
        chk(v.op[1] ? "R8 register read low" : "R7 read low byte",
            {22'd0, dq_oe, rwds_out, dq_out}, {22'd0, 1'b1, 1'b0, e[7:0]});
        if (k == 0) chk("R9 first word vector", {16'd0, e}, {16'd0, v.exp0});
      end else begin
        w = v.seed + 16'(k) * 16'h0101;
        mh = (k == 0) ? v.mask[3] : ((k == 1) ? v.mask[1] : 1'b0);
        ml = (k == 0) ? v.mask[2] : ((k == 1) ? v.mask[0] : 1'b0);
        bus_edge(w[15:8], mh);
        bus_edge(w[7:0], ml);
        if (!v.op[1]) begin
          if (!mh) shadow[a][15:8] = w[15:8];
          if (!ml) shadow[a][7:0] = w[7:0];
        end else if (a == 8'd1 && !ml) begin
          fixed_m = w[0];
        end
      end
      a = next_a(a, v.lin);
    end
    close_txn();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = 16'h0000;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: outputs released after reset
    chk("R11 reset outputs", {30'd0, dq_oe, rwds_oe}, 32'd0);

    for (int v = 0; v < NV; v++) run_vec(VECS[v]);

    // R10: abort mid-word leaves the stored word intact
    run_vec('{2'd0, 1'b1, 22'h000040, 4'd1, 16'h1111, 4'h0, 16'h0000});
    open_txn(1'b0, 1'b0, 1'b1, 22'h000040);
    bus_edge(8'h99, 1'b0);
    close_txn();
    run_vec('{2'd1, 1'b1, 22'h000040, 4'd1, 16'h0000, 4'h0, 16'h1111});

    // R10: abort during a read burst, then a fresh header works
    open_txn(1'b1, 1'b0, 1'b1, 22'h000010);
    bus_edge(8'h00, 1'b0);
    chk("R10 read before abort", {24'd0, dq_out}, 32'hA1);
    close_txn();
    run_vec('{2'd1, 1'b0, 22'h00002F, 4'd2, 16'h0000, 4'h0, 16'hB312});

    // R5: idle bus-clock cycles bring a refresh due, then two back-to-back reads
    for (int i = 0; i < 2 * RP; i++) bus_edge(8'h00, 1'b0);
    run_vec('{2'd1, 1'b1, 22'h000011, 4'd1, 16'h0000, 4'h0, 16'hA201});
    run_vec('{2'd1, 1'b1, 22'h000013, 4'd1, 16'h0000, 4'h0, 16'hA403});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule